// File: doc/BRIEF.md
# Polling-Exit Controller for Multi-Lane Link Training

This block decides when a multi-lane serial link may leave the active polling substate of link training. It starts working on a one-cycle start pulse. From then on it watches three things. The first is the training ordered sets received on each lane. The second is the number of TS1 ordered sets the local transmitter has sent. The third is whether each lane has left electrical idle. When it reaches a verdict, it raises a one-cycle request to move on to the configuration substate or to fall back to receiver detection.

There are two ways to pass. On the normal path, every lane that found a receiver must have received a run of eight good training sets, and enough TS1 sets must have been sent. When a timer expires, a relaxed rule applies instead. A single trained lane is enough, as long as enough TS1 sets were sent after the first training set arrived and a programmable minimum number of detected lanes have left electrical idle. A minimum of one lets a link with broken lanes still train.

Top module: `poll_exit_ctrl`

## Requirements
- R1: After reset, both decision outputs are low, and no decision is made until a start pulse has been sampled, whatever the other inputs do.
- R2: On a detected lane, a received ordered set with kind code 2'b01 (TS1) or 2'b10 (TS2) and the broken flag low adds one to that lane's run count. The count saturates at TS_RUN (8) and does not wrap.
- R3: On a detected lane, a received ordered set that has the broken flag set, or that has kind code 2'b00 or 2'b11, clears that lane's run count to zero.
- R4: Normal exit: go_cfg_o pulses for one cycle when every detected lane has a full run and the total TS1-sent count has reached TX_TARGET. The pulse appears one clock edge after the edge that sampled the last missing input.
- R5: Lanes whose rx_det_i bit is low are ignored by every lane condition and every lane count, including received sets and idle-exit indications.
- R6: Timeout exit: the timer expires at the TIMEOUT_CYC-th clock edge after the edge that sampled the start pulse, and the decision becomes visible right after that edge. If the normal rule does not hold at that point, go_cfg_o pulses when three things hold: at least one detected lane has a full run, the post-reception TS1 count has reached TX_TARGET, and the idle-exit count meets min_lanes_i.
- R7: The post-reception TS1 count counts only the TS1-sent pulses sampled after the edge on which the first good training set arrived on any detected lane. A pulse that arrives on the same edge as that first set is not counted.
- R8: Each detected lane's idle-exit flag is sticky until the next start pulse. The idle condition at timeout holds when the number of flagged detected lanes is at least min_lanes_i (0 to LANES).
- R9: If the timeout rule fails when the timer expires, go_detect_o pulses for one cycle instead.
- R10: A start pulse clears every count, flag and the timer and begins a new attempt. After a decision, no further decision is made until the next start pulse.
- R11: go_cfg_o and go_detect_o are never high together, and each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Entry into active polling; clears all state and starts an attempt |
| rx_det_i | input | LANES | Lanes that detected a receiver (held stable) |
| os_vld_i | input | LANES | Per-lane pulse: an ordered set was received |
| os_kind_i | input | 2*LANES | Per-lane kind: 01 TS1, 10 TS2, 00/11 other set |
| os_bad_i | input | LANES | Per-lane: the received set is broken |
| eidle_exit_i | input | LANES | Per-lane electrical-idle exit indication |
| tx_ts1_i | input | 1 | Pulse per TS1 ordered set transmitted |
| min_lanes_i | input | $clog2(LANES+1) | Required number of idle-exited lanes for the timeout path |
| go_cfg_o | output | 1 | One-cycle request to move to configuration |
| go_detect_o | output | 1 | One-cycle request to fall back to detection |

## Verification
The bench goes after several corner cases, each with its own failure.

- A lane run interrupted by a broken set or a non-training kind: a design that kept the count would let an untrained lane pass.
- Runs longer than sixteen sets: a count that wraps would drop a trained lane back below eight.
- The total TS1 count reaching its target one pulse late: an off-by-one would fire early or never.
- TS1 pulses sent before, or in the same cycle as, the first reception: a design that counted them would accept a timeout exit that should fall back to detection.
- A sweep of every idle-exit pattern against every minimum-lane setting, with one lane undetected: a design that counted undetected lanes, or compared with the wrong inequality, would pick the wrong verdict.
- Restarts in the middle of an attempt, and stimulus after a decision: a design that missed them would act on stale counts or issue a second verdict.

// File: rtl/pe_pkg.sv
// Package: shared definitions for the polling-exit controller.
// Assumes: nothing; types only.
package pe_pkg;
    // Two-bit kind code carried with every received ordered set
    typedef enum logic [1:0] {
        OS_OTHER0 = 2'b00,
        OS_TS1    = 2'b01,
        OS_TS2    = 2'b10,
        OS_OTHER3 = 2'b11
    } os_kind_e;

    // Returns 1 when a kind code is a training sequence of either type
    function automatic logic is_training(input logic [1:0] kind);
        return (kind == OS_TS1) || (kind == OS_TS2);
    endfunction
endpackage

// File: rtl/pe_lane_trk.sv
// Module: pe_lane_trk
// Tracks one lane: a saturating count of consecutive good training sets and
// a sticky electrical-idle-exit flag. Assumes det is stable during an attempt;
// an undetected lane holds both values at zero.
module pe_lane_trk
    import pe_pkg::*;
#(
    parameter int TS_RUN = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic       det,
    input  logic       os_vld,
    input  logic [1:0] os_kind,
    input  logic       os_bad,
    input  logic       eidle_exit,
    output logic       passed,
    output logic       got_ts,
    output logic       idle_seen
);
    localparam int CW = $clog2(TS_RUN + 1);

    logic [CW-1:0] run_q;
    logic          idle_q;
    logic          good_os;

    // Classify this cycle's received set as a good training sequence
    always_comb good_os = os_vld && !os_bad && is_training(os_kind);

    // Consecutive-run counter: saturate on good sets, clear on anything else
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run_q <= '0;
        end else if (en && det && os_vld) begin
            if (good_os) begin
                if (run_q != CW'(TS_RUN)) run_q <= run_q + 1'b1;
            end else begin
                run_q <= '0;
            end
        end
    end

    // Sticky idle-exit flag for this lane
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                idle_q <= 1'b0;
        else if (en && det && eidle_exit) idle_q <= 1'b1;
    end

    // Lane status presented to the decision logic
    always_comb begin
        passed    = det && (run_q == CW'(TS_RUN));
        got_ts    = en && det && good_os;
        idle_seen = det && idle_q;
    end

    p_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= CW'(TS_RUN));
    p_break_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && det && os_vld && !good_os && !clr) |=> (run_q == '0));
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_q && !clr) |=> idle_q);
endmodule

// File: rtl/pe_tx_cnt.sv
// Module: pe_tx_cnt
// Counts transmitted TS1 sets twice: a total since start, and a count that
// only begins after the first good training set has been received. Both
// saturate at TX_TARGET. Assumes clr is the start pulse.
module pe_tx_cnt #(
    parameter int TX_TARGET = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic tx_ts1,
    input  logic any_rx,
    output logic tot_done,
    output logic post_done
);
    localparam int TW = $clog2(TX_TARGET + 1);

    logic [TW-1:0] tot_q;
    logic [TW-1:0] post_q;
    logic          started_q;

    // Total transmitted-TS1 counter
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                            tot_q <= '0;
        else if (en && tx_ts1 && tot_q != TW'(TX_TARGET)) tot_q <= tot_q + 1'b1;
    end

    // Marks that the first good training set has arrived
    always_ff @(posedge clk) begin
        if (!rst_n || clr)     started_q <= 1'b0;
        else if (en && any_rx) started_q <= 1'b1;
    end

    // Post-first-reception transmitted-TS1 counter
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            post_q <= '0;
        else if (en && started_q && tx_ts1 && post_q != TW'(TX_TARGET))
            post_q <= post_q + 1'b1;
    end

    // Threshold flags
    always_comb begin
        tot_done  = (tot_q == TW'(TX_TARGET));
        post_done = (post_q == TW'(TX_TARGET));
    end

    p_post_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!started_q && !clr) |=> (post_q == $past(post_q)));
    p_post_le_tot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        post_q <= tot_q);
endmodule

// File: rtl/pe_timer.sv
// Module: pe_timer
// Timeout timer for one polling attempt: counts enabled cycles from clr and
// flags the cycle in which TIMEOUT_CYC edges have elapsed. Assumes TIMEOUT_CYC >= 2.
module pe_timer #(
    parameter int TIMEOUT_CYC = 6000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic hit
);
    localparam int MW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [MW-1:0] LAST = MW'(TIMEOUT_CYC - 1);

    logic [MW-1:0] t_q;

    // Cycle counter, holds at the last value
    always_ff @(posedge clk) begin
        if (!rst_n || clr)         t_q <= '0;
        else if (en && t_q != LAST) t_q <= t_q + 1'b1;
    end

    // Expiry flag
    always_comb hit = en && (t_q == LAST);

    p_tmr_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        t_q <= LAST);
endmodule

// File: rtl/poll_exit_ctrl.sv
// Module: poll_exit_ctrl (top)
// Decides the exit from active polling: the normal path when all detected lanes
// are trained, the timeout path for a degraded link, or fallback to detection.
// Assumes rx_det_i and min_lanes_i are stable for the duration of an attempt.
module poll_exit_ctrl
    import pe_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int TS_RUN      = 8,
    parameter int TX_TARGET   = 1024,
    parameter int TIMEOUT_CYC = 6000000,
    localparam int LCW        = $clog2(LANES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [LANES-1:0]   rx_det_i,
    input  logic [LANES-1:0]   os_vld_i,
    input  logic [2*LANES-1:0] os_kind_i,
    input  logic [LANES-1:0]   os_bad_i,
    input  logic [LANES-1:0]   eidle_exit_i,
    input  logic               tx_ts1_i,
    input  logic [LCW-1:0]     min_lanes_i,
    output logic               go_cfg_o,
    output logic               go_detect_o
);
    logic             active_q;
    logic [LANES-1:0] passed;
    logic [LANES-1:0] got_ts;
    logic [LANES-1:0] idle_seen;
    logic             tot_done, post_done, tmo_hit;
    logic [LCW-1:0]   idle_cnt;
    logic             all_pass, any_pass, idle_ok, norm_ok, alt_ok;

    // One tracker per lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pe_lane_trk #(.TS_RUN(TS_RUN)) i_trk (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr        (start_i),
            .en         (active_q),
            .det        (rx_det_i[g]),
            .os_vld     (os_vld_i[g]),
            .os_kind    (os_kind_i[2*g +: 2]),
            .os_bad     (os_bad_i[g]),
            .eidle_exit (eidle_exit_i[g]),
            .passed     (passed[g]),
            .got_ts     (got_ts[g]),
            .idle_seen  (idle_seen[g])
        );
    end

    pe_tx_cnt #(.TX_TARGET(TX_TARGET)) i_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start_i),
        .en        (active_q),
        .tx_ts1    (tx_ts1_i),
        .any_rx    (|got_ts),
        .tot_done  (tot_done),
        .post_done (post_done)
    );

    pe_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_i),
        .en    (active_q),
        .hit   (tmo_hit)
    );

    // Count detected lanes that have left electrical idle
    always_comb begin
        idle_cnt = '0;
        for (int i = 0; i < LANES; i++) idle_cnt = idle_cnt + LCW'(idle_seen[i]);
    end

    // Exit conditions for both paths
    always_comb begin
        all_pass = (&(passed | ~rx_det_i)) && (|rx_det_i);
        any_pass = |passed;
        idle_ok  = (idle_cnt >= min_lanes_i);
        norm_ok  = tot_done && all_pass;
        alt_ok   = any_pass && post_done && idle_ok;
    end

    // Attempt state and registered one-cycle decisions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q    <= 1'b0;
            go_cfg_o    <= 1'b0;
            go_detect_o <= 1'b0;
        end else begin
            go_cfg_o    <= 1'b0;
            go_detect_o <= 1'b0;
            if (start_i) begin
                active_q <= 1'b1;
            end else if (active_q) begin
                if (norm_ok) begin
                    go_cfg_o <= 1'b1;
                    active_q <= 1'b0;
                end else if (tmo_hit) begin
                    go_cfg_o    <= alt_ok;
                    go_detect_o <= !alt_ok;
                    active_q    <= 1'b0;
                end
            end
        end
    end

    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(go_cfg_o && go_detect_o));
    p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (go_cfg_o || go_detect_o) |=> !(go_cfg_o || go_detect_o));
    p_start_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !(go_cfg_o || go_detect_o));
    p_det_on_tmo_r9: assert property (@(posedge clk) disable iff (!rst_n)
        go_detect_o |-> $past(tmo_hit));
    p_norm_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (go_cfg_o && !$past(tmo_hit)) |-> $past(tot_done && all_pass));
endmodule

// File: tb/test_poll_exit_ctrl.sv
// Bench for poll_exit_ctrl: directed scenarios plus a sweep of idle-exit
// patterns against every minimum-lane setting.
module test_poll_exit_ctrl;
    localparam int CLK_PER = 10;
    localparam int NL      = 4;
    localparam int RUN     = 8;
    localparam int TXT     = 16;
    localparam int TMO     = 300;
    localparam int LW      = $clog2(NL + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [NL-1:0]   rx_det_i = '0;
    logic [NL-1:0]   os_vld_i = '0;
    logic [2*NL-1:0] os_kind_i = '0;
    logic [NL-1:0]   os_bad_i = '0;
    logic [NL-1:0]   eidle_exit_i = '0;
    logic            tx_ts1_i = 1'b0;
    logic [LW-1:0]   min_lanes_i = '0;
    logic            go_cfg_o, go_detect_o;

    int n_chk = 0, n_fail = 0;
    int n_cfg = 0, n_det = 0, n_viol = 0;
    int since = 0;
    logic prev_go = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    poll_exit_ctrl #(.LANES(NL), .TS_RUN(RUN), .TX_TARGET(TXT), .TIMEOUT_CYC(TMO)) i_poll_exit_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rx_det_i(rx_det_i),
        .os_vld_i(os_vld_i), .os_kind_i(os_kind_i), .os_bad_i(os_bad_i),
        .eidle_exit_i(eidle_exit_i), .tx_ts1_i(tx_ts1_i), .min_lanes_i(min_lanes_i),
        .go_cfg_o(go_cfg_o), .go_detect_o(go_detect_o)
    );

    // Edges since the last sampled start pulse
    always @(posedge clk) begin
        if (!rst_n || start_i) since <= 0;
        else                   since <= since + 1;
    end

    // Event monitor: counts decisions and width/overlap violations (R11)
    always @(negedge clk) begin
        if (rst_n) begin
            if (go_cfg_o) n_cfg++;
            if (go_detect_o) n_det++;
            if (go_cfg_o && go_detect_o) n_viol++;
            if ((go_cfg_o || go_detect_o) && prev_go) n_viol++;
            prev_go = go_cfg_o || go_detect_o;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // One ordered-set pulse on the lanes in mask, same kind on each
    task automatic os(input logic [NL-1:0] mask, input logic [1:0] kind, input logic bad);
        os_vld_i = mask;
        for (int i = 0; i < NL; i++) os_kind_i[2*i +: 2] = kind;
        os_bad_i = {NL{bad}};
        @(negedge clk);
        os_vld_i = '0; os_bad_i = '0; os_kind_i = '0;
    endtask

    task automatic train(input logic [NL-1:0] mask, input int n);
        for (int i = 0; i < n; i++) os(mask, (i % 2 == 0) ? 2'b01 : 2'b10, 1'b0);
    endtask

    task automatic tx(input int n);
        for (int i = 0; i < n; i++) begin
            tx_ts1_i = 1'b1;
            @(negedge clk);
            tx_ts1_i = 1'b0;
        end
    endtask

    task automatic idle(input logic [NL-1:0] mask);
        eidle_exit_i = mask;
        @(negedge clk);
        eidle_exit_i = '0;
    endtask

    // Waits for a decision; kind 0 none, 1 cfg, 2 detect
    task automatic wait_dec(output int kind, output int at);
        kind = 0; at = -1;
        for (int i = 0; i < TMO + 40 && kind == 0; i++) begin
            @(negedge clk);
            if (go_cfg_o)         begin kind = 1; at = since; end
            else if (go_detect_o) begin kind = 2; at = since; end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        int k, at, c0, d0;
        cyc(3);
        // R1: outputs low in reset
        chk(!go_cfg_o && !go_detect_o, "R1 reset outputs", go_cfg_o + go_detect_o, 0);
        rst_n = 1'b1;
        rx_det_i = '1; min_lanes_i = 1;
        // R1: no decision without a start, even with full stimulus and long wait
        train('1, RUN); tx(TXT); idle('1); cyc(TMO + 20);
        chk(n_cfg + n_det == 0, "R1 no decision before start", n_cfg + n_det, 0);

        // R2 R4: normal exit with TS1/TS2 mix; latency and TX boundary
        start(); train('1, RUN); tx(TXT - 1); cyc(2);
        chk(!go_cfg_o && n_cfg == 0, "R4 one TS1 short", n_cfg, 0);
        tx(1);
        chk(!go_cfg_o, "R4 latency before", go_cfg_o, 0);
        cyc(1);
        chk(go_cfg_o == 1'b1, "R4 cfg pulse", go_cfg_o, 1);
        cyc(1);
        chk(!go_cfg_o, "R11 one-cycle pulse", go_cfg_o, 0);
        // R10: no further decision after a verdict
        c0 = n_cfg; d0 = n_det;
        tx(TXT); train('1, 2); cyc(TMO + 20);
        chk(n_cfg == c0 && n_det == d0, "R10 quiet after decision", n_cfg + n_det - c0 - d0, 0);

        // R3 R2: broken and non-training sets clear runs; no wrap past 16
        start(); train('1, RUN - 1);
        os_vld_i = '1; os_kind_i = 8'b01_01_11_01; os_bad_i = 4'b0100;
        @(negedge clk); os_vld_i = '0; os_kind_i = '0; os_bad_i = '0;
        train('1, RUN - 1); train(4'b1001, 16); tx(TXT); cyc(2);
        chk(n_cfg == c0 + 0 && !go_cfg_o, "R3 broken lanes block", n_cfg - c0, 0);
        train(4'b0100, 1); cyc(2);
        chk(n_cfg == c0 && !go_cfg_o, "R3 kind 11 lane still blocks", n_cfg - c0, 0);
        train(4'b0010, 1);
        cyc(1);
        chk(go_cfg_o == 1'b1, "R2 saturated lanes still pass", go_cfg_o, 1);
        cyc(2);

        // R5: undetected lanes ignored (junk on them)
        rx_det_i = 4'b0101;
        start(); os(4'b1010, 2'b01, 1'b1); train(4'b0101, RUN); os(4'b1010, 2'b11, 1'b0); tx(TXT);
        wait_dec(k, at);
        chk(k == 1 && at < TMO, "R5 undetected lanes masked", k, 1);

        // R6 R8: timeout path with one good lane, min one
        rx_det_i = '1; min_lanes_i = 1;
        start(); train(4'b0001, RUN); idle(4'b0001); tx(TXT);
        wait_dec(k, at);
        chk(k == 1, "R6 degraded cfg", k, 1);
        chk(at == TMO, "R6 timeout edge", at, TMO);

        // R7: TS1 before/with first reception not counted
        start(); tx(5);
        os_vld_i = 4'b0001; os_kind_i = 8'h01; tx_ts1_i = 1'b1;
        @(negedge clk); os_vld_i = '0; os_kind_i = '0; tx_ts1_i = 1'b0;
        train(4'b0001, RUN - 1); idle(4'b0001); tx(TXT - 1);
        wait_dec(k, at);
        chk(k == 2, "R7 early TS1 not counted", k, 2);
        chk(at == TMO, "R9 detect at timeout edge", at, TMO);

        // R9: nothing trained
        start(); idle('1); tx(TXT);
        wait_dec(k, at);
        chk(k == 2, "R9 untrained falls back", k, 2);

        // R10: restart mid-attempt clears progress
        start(); train('1, RUN); tx(TXT - 4);
        start(); tx(4);
        wait_dec(k, at);
        chk(k == 2 && at == TMO, "R10 restart clears state", k, 2);

        // R8 R5: sweep idle patterns x min lanes, lane 3 undetected
        rx_det_i = 4'b0111;
        for (int m = 0; m <= NL; m++) begin
            for (int im = 0; im < 16; im++) begin
                int exp_k;
                min_lanes_i = LW'(m);
                start(); train(4'b0001, RUN); idle(4'(im)); tx(TXT);
                wait_dec(k, at);
                exp_k = ($countones(im & 7) >= m) ? 1 : 2;
                chk(k == exp_k && at == TMO, "R8 idle count vs min", k, exp_k);
            end
        end

        cyc(3);
        chk(n_viol == 0, "R11 exclusive single-cycle pulses", n_viol, 0);
        summary();
    end
endmodule